// File: doc/BRIEF.md
# Key-Locked Control Register Bank with Expiry Timer

This block holds a small set of control registers behind a byte-wide index/data write port and a combinational index/read port. A two-wire management slave outside the block turns bus transactions into these single-cycle write strobes and read indices. The register values drive the rest of the design directly through dedicated output ports.

Seven of the registers are protected. They only take writes after an exact four-byte key sequence has been written to the key index. A single lock byte closes the bank again. A down-counting expiry timer is armed through its own register. When it runs out, it clears the protected registers, re-locks the bank and disarms itself. An optional clear from an active-low socket-occupied pin does the same to the registers and the key state.

Top module: `keyed_reg_bank`

## Requirements
- R1: After reset, every protected register is 0, the bank is locked, index 0x03 reads 0x00, index 0x0F reads 0x00 and index 0x13 reads 0x00.
- R2: Writing 0x32, 0x5D, 0x42 and then 0xAC to index 0x03 unlocks the bank. While the bank is unlocked, index 0x03 reads 0xFF and unlocked_o is 1. While it is locked, index 0x03 reads 0x00.
- R3: A byte that breaks the key sequence sends the tracker back to its start. If the breaking byte is 0x32, it counts as the first byte of a new attempt.
- R4: While the bank is unlocked, writing 0x35 to index 0x03 locks it. Any other byte written to index 0x03 while unlocked has no effect.
- R5: The protected registers are at indices 0x04 to 0x0A (three offsets, a step time, two over-voltage selects and a manual-enable field). They take writes only while the bank is unlocked. Writes while it is locked are dropped.
- R6: Index 0x0A keeps only bits 2:0, and its bits 7:3 read as 0. Index 0x0F keeps only bit 0. Unmapped indices read 0x00.
- R7: The fixed identification indices read as follows: 0x5A reads 0x07, 0x5C reads 0x30, 0x5D reads 0x19 and 0x5E reads 0x34.
- R8: A write to index 0x13 loads the enable (bit 7) and the count (bits 6:0). While the timer is enabled, the count drops by one every PRESC_DIV cycles. Index 0x13 reads back {enable, current count}.
- R9: When an armed count of N is written, wdt_fire_o pulses high for exactly one cycle, (N+1)*PRESC_DIV cycles after the write edge. In that same cycle the enable bit reads 0. On the next edge the protected registers clear and the bank locks.
- R10: A new write to index 0x13 while the timer runs restarts both the count and the prescaler.
- R11: When bit 0 of index 0x0F is 1, a low level on slot_occ_ni clears the protected registers and locks the bank within three cycles. Index 0x0F itself keeps its value. When that bit is 0, the pin has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_idx_i | input | 8 | Write index |
| wr_data_i | input | 8 | Write data |
| rd_idx_i | input | 8 | Read index |
| rd_data_o | output | 8 | Read data for rd_idx_i (combinational) |
| slot_occ_ni | input | 1 | Socket-occupied pin, active low, asynchronous |
| unlocked_o | output | 1 | Bank is unlocked |
| wdt_fire_o | output | 1 | One-cycle pulse when the timer expires |
| nb_ofs_o | output | 8 | Offset register, index 0x04 |
| c0_ofs_o | output | 8 | Offset register, index 0x05 |
| c1_ofs_o | output | 8 | Offset register, index 0x06 |
| step_o | output | 8 | Step-time register, index 0x07 |
| ovs0_o | output | 8 | Over-voltage select A, index 0x08 |
| ovs1_o | output | 8 | Over-voltage select B, index 0x09 |
| man_en_o | output | 3 | Manual-enable field, index 0x0A |

## Verification
The hardest situation to reach is a broken key attempt whose breaking byte is itself the first key byte. After a wrong byte, the tracker must restart at stage one rather than stage zero. The bench drives 0x32 twice and then completes the sequence, and it also drives a sequence that breaks mid-way on another byte. For timer expiry, the bench counts cycles from the arming write to the pulse. The count is compared with (N+1)*PRESC_DIV at a small prescaler, and a rewrite of the timer register in mid-count must move the pulse to match.

// File: rtl/krb_pkg.sv
package krb_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned NUM_PROT = 7;
  localparam int unsigned SEL_W    = $clog2(NUM_PROT);

  localparam logic [7:0] IDX_KEY   = 8'h03;
  localparam logic [7:0] IDX_PROT  = 8'h04;
  localparam logic [7:0] IDX_PEND  = IDX_PROT + 8'(NUM_PROT);
  localparam logic [7:0] IDX_SLOT  = 8'h0F;
  localparam logic [7:0] IDX_WDT   = 8'h13;
  localparam logic [7:0] KEY_LOCK  = 8'h35;
  localparam logic [7:0] KEY_OPEN  = 8'hFF;

  function automatic logic [7:0] key_byte(input logic [1:0] stage);
    case (stage)
      2'd0:    key_byte = 8'h32;
      2'd1:    key_byte = 8'h5D;
      2'd2:    key_byte = 8'h42;
      default: key_byte = 8'hAC;
    endcase
  endfunction

  function automatic logic [7:0] prot_mask(input int unsigned n);
    prot_mask = (n == NUM_PROT - 1) ? 8'h07 : 8'hFF;
  endfunction

  function automatic logic [7:0] id_byte(input logic [7:0] idx);
    case (idx)
      8'h5A:   id_byte = 8'h07;
      8'h5C:   id_byte = 8'h30;
      8'h5D:   id_byte = 8'h19;
      8'h5E:   id_byte = 8'h34;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/krb_sync.sv
module krb_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/krb_key_fsm.sv
module krb_key_fsm
  import krb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  output logic          unlocked_o
);
  logic [1:0] stage_q, stage_d;
  logic       open_q, open_d;

  always_comb begin
    stage_d = stage_q;
    open_d  = open_q;
    if (clr_i) begin
      stage_d = '0;
      open_d  = 1'b0;
    end else if (wr_i) begin
      if (open_q) begin
        if (data_i == KEY_LOCK) open_d = 1'b0;
      end else if (data_i == key_byte(stage_q)) begin
        if (stage_q == 2'd3) begin
          open_d  = 1'b1;
          stage_d = '0;
        end else begin
          stage_d = stage_q + 2'd1;
        end
      end else begin
        // a stray first key byte restarts the attempt at stage one
        stage_d = (data_i == key_byte(2'd0)) ? 2'd1 : 2'd0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      open_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      open_q  <= open_d;
    end
  end

  assign unlocked_o = open_q;
endmodule

// File: rtl/krb_wdt.sv
module krb_wdt #(
  parameter int unsigned PRESC_DIV = 1000,
  parameter int unsigned CW        = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [CW:0] load_data_i,
  output logic        en_o,
  output logic [CW-1:0] cnt_o,
  output logic        fire_o
);
  localparam int unsigned PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(PRESC_DIV - 1);

  logic [PW-1:0] presc_q;
  logic [CW-1:0] cnt_q;
  logic          en_q, fire_q;
  logic          tick;

  assign tick = en_q && (presc_q == P_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      cnt_q   <= '0;
      en_q    <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (load_i) begin
        en_q    <= load_data_i[CW];
        cnt_q   <= load_data_i[CW-1:0];
        presc_q <= '0;
      end else if (en_q) begin
        presc_q <= tick ? '0 : presc_q + 1'b1;
        if (tick) begin
          if (cnt_q == '0) begin
            fire_q <= 1'b1;
            en_q   <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end

  assign en_o   = en_q;
  assign cnt_o  = cnt_q;
  assign fire_o = fire_q;
endmodule

// File: rtl/krb_prot_regs.sv
module krb_prot_regs
  import krb_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        wr_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [DW-1:0]               data_i,
  output logic [NUM_PROT-1:0][DW-1:0] q_o
);
  for (genvar g = 0; g < NUM_PROT; g++) begin : g_reg
    localparam logic [DW-1:0] MASK = prot_mask(g);
    logic [DW-1:0] r_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  r_q <= '0;
      else if (clr_i)                               r_q <= '0;
      else if (wr_i && sel_i == SEL_W'(g))          r_q <= data_i & MASK;
    end

    assign q_o[g] = r_q;
  end
endmodule

// File: rtl/keyed_reg_bank.sv
module keyed_reg_bank
  import krb_pkg::*;
#(
  parameter int unsigned PRESC_DIV   = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  input  logic [7:0] rd_idx_i,
  output logic [7:0] rd_data_o,
  input  logic       slot_occ_ni,
  output logic       unlocked_o,
  output logic       wdt_fire_o,
  output logic [7:0] nb_ofs_o,
  output logic [7:0] c0_ofs_o,
  output logic [7:0] c1_ofs_o,
  output logic [7:0] step_o,
  output logic [7:0] ovs0_o,
  output logic [7:0] ovs1_o,
  output logic [2:0] man_en_o
);
  localparam int unsigned CW = DW - 1;

  logic                        unlocked, wdt_en, wdt_fire, slot_s, slot_en_q, clr;
  logic [CW-1:0]               wdt_cnt;
  logic [NUM_PROT-1:0][DW-1:0] prot_q;
  logic                        wr_key, wr_prot, wr_wdt, wr_slot;
  logic [SEL_W-1:0]            wr_sel, rd_sel;
  logic                        rd_in_prot;

  assign wr_key  = wr_en_i && (wr_idx_i == IDX_KEY);
  assign wr_wdt  = wr_en_i && (wr_idx_i == IDX_WDT);
  assign wr_slot = wr_en_i && (wr_idx_i == IDX_SLOT);
  assign wr_prot = wr_en_i && unlocked &&
                   (wr_idx_i >= IDX_PROT) && (wr_idx_i < IDX_PEND);
  assign wr_sel  = SEL_W'(wr_idx_i - IDX_PROT);

  krb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_slot_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (slot_occ_ni),
    .q_o   (slot_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      slot_en_q <= 1'b0;
    else if (wr_slot) slot_en_q <= wr_data_i[0];
  end

  assign clr = wdt_fire || (slot_en_q && !slot_s);

  krb_key_fsm u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .wr_i      (wr_key),
    .data_i    (wr_data_i),
    .unlocked_o(unlocked)
  );

  krb_wdt #(.PRESC_DIV(PRESC_DIV), .CW(CW)) u_wdt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_wdt),
    .load_data_i(wr_data_i),
    .en_o       (wdt_en),
    .cnt_o      (wdt_cnt),
    .fire_o     (wdt_fire)
  );

  krb_prot_regs u_regs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .wr_i  (wr_prot),
    .sel_i (wr_sel),
    .data_i(wr_data_i),
    .q_o   (prot_q)
  );

  assign rd_in_prot = (rd_idx_i >= IDX_PROT) && (rd_idx_i < IDX_PEND);
  assign rd_sel     = SEL_W'(rd_idx_i - IDX_PROT);

  always_comb begin
    if (rd_in_prot)                 rd_data_o = prot_q[rd_sel];
    else if (rd_idx_i == IDX_KEY)   rd_data_o = unlocked ? KEY_OPEN : 8'h00;
    else if (rd_idx_i == IDX_SLOT)  rd_data_o = {7'b0, slot_en_q};
    else if (rd_idx_i == IDX_WDT)   rd_data_o = {wdt_en, wdt_cnt};
    else                            rd_data_o = id_byte(rd_idx_i);
  end

  assign unlocked_o = unlocked;
  assign wdt_fire_o = wdt_fire;
  assign nb_ofs_o   = prot_q[0];
  assign c0_ofs_o   = prot_q[1];
  assign c1_ofs_o   = prot_q[2];
  assign step_o     = prot_q[3];
  assign ovs0_o     = prot_q[4];
  assign ovs1_o     = prot_q[5];
  assign man_en_o   = prot_q[6][2:0];
endmodule

// File: rtl/krb_checker.sv
module krb_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_idx_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_idx_i,
  input logic [7:0] rd_data_o,
  input logic       unlocked_o,
  input logic       wdt_fire_o,
  input logic [7:0] step_o,
  input logic       wdt_en_i
);
  AST_UNLOCK_NEEDS_LAST_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(wr_en_i && wr_idx_i == 8'h03 && wr_data_i == 8'hAC)); // R2

  AST_KEY_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i == 8'h03) |-> (rd_data_o == (unlocked_o ? 8'hFF : 8'h00))); // R2

  AST_LOCKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_o |=> (step_o == $past(step_o) || step_o == 8'h00)); // R5

  AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i == 8'h0A) |-> (rd_data_o[7:3] == 5'b0)); // R6

  AST_FIRE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_fire_o |=> !wdt_fire_o); // R9

  AST_FIRE_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_fire_o |-> !wdt_en_i); // R9

  AST_FIRE_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_fire_o |=> !unlocked_o); // R9
endmodule

bind keyed_reg_bank krb_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_idx_i  (wr_idx_i),
  .wr_data_i (wr_data_i),
  .rd_idx_i  (rd_idx_i),
  .rd_data_o (rd_data_o),
  .unlocked_o(unlocked_o),
  .wdt_fire_o(wdt_fire_o),
  .step_o    (step_o),
  .wdt_en_i  (wdt_en)
);

// File: tb/keyed_reg_bank_tb_top.sv
`timescale 1ns/1ps
module keyed_reg_bank_tb_top;
  localparam int unsigned DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_idx = '0, wr_data = '0, rd_idx = '0;
  logic [7:0] rd_data;
  logic slot_n = 1'b1;
  logic unlocked, fire;
  logic [7:0] nb_ofs, c0_ofs, c1_ofs, step, ovs0, ovs1;
  logic [2:0] man_en;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  keyed_reg_bank #(.PRESC_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .slot_occ_ni(slot_n), .unlocked_o(unlocked), .wdt_fire_o(fire),
    .nb_ofs_o(nb_ofs), .c0_ofs_o(c0_ofs), .c1_ofs_o(c1_ofs), .step_o(step),
    .ovs0_o(ovs0), .ovs1_o(ovs1), .man_en_o(man_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] idx, output logic [7:0] d);
    @(negedge clk);
    rd_idx = idx;
    #1 d = rd_data;
  endtask

  task automatic unlock();
    wr(8'h03, 8'h32); wr(8'h03, 8'h5D); wr(8'h03, 8'h42); wr(8'h03, 8'hAC);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h03, d); chk("R1 key idx", d, 8'h00);
    rd(8'h0F, d); chk("R1 slot idx", d, 8'h00);
    rd(8'h13, d); chk("R1 wdt idx", d, 8'h00);
    chk("R1 step", step, 0);
    chk("R1 unlocked", unlocked, 0);
  endtask

  task automatic t_unlock();
    logic [7:0] d;
    unlock();
    chk("R2 unlocked_o", unlocked, 1);
    rd(8'h03, d); chk("R2 key reads FF", d, 8'hFF);
  endtask

  task automatic t_relock();
    logic [7:0] d;
    wr(8'h03, 8'h12);
    rd(8'h03, d); chk("R4 other byte ignored", d, 8'hFF);
    wr(8'h03, 8'h35);
    rd(8'h03, d); chk("R4 lock byte", d, 8'h00);
  endtask

  task automatic t_bad_seq();
    logic [7:0] d;
    wr(8'h03, 8'h32); wr(8'h03, 8'h5D); wr(8'h03, 8'h00);
    wr(8'h03, 8'h42); wr(8'h03, 8'hAC);
    rd(8'h03, d); chk("R3 broken sequence stays locked", d, 8'h00);
    wr(8'h03, 8'h32); wr(8'h03, 8'h32); wr(8'h03, 8'h5D);
    wr(8'h03, 8'h42); wr(8'h03, 8'hAC);
    rd(8'h03, d); chk("R3 repeated first byte restarts", d, 8'hFF);
    wr(8'h03, 8'h35);
  endtask

  task automatic t_protect();
    logic [7:0] d;
    wr(8'h07, 8'h5A);
    chk("R5 locked write dropped", step, 8'h00);
    unlock();
    wr(8'h04, 8'h11); wr(8'h05, 8'h22); wr(8'h06, 8'h33); wr(8'h07, 8'h44);
    wr(8'h08, 8'h55); wr(8'h09, 8'h66); wr(8'h0A, 8'hFF);
    chk("R5 nb ofs", nb_ofs, 8'h11); chk("R5 c0 ofs", c0_ofs, 8'h22);
    chk("R5 c1 ofs", c1_ofs, 8'h33); chk("R5 step", step, 8'h44);
    chk("R5 ovs0", ovs0, 8'h55);     chk("R5 ovs1", ovs1, 8'h66);
    chk("R6 man_en bits", man_en, 3'h7);
    rd(8'h0A, d); chk("R6 reserved bits zero", d, 8'h07);
    rd(8'h07, d); chk("R5 readback", d, 8'h44);
    wr(8'h03, 8'h35);
    wr(8'h07, 8'h99);
    rd(8'h07, d); chk("R5 write after relock dropped", d, 8'h44);
    rd(8'h20, d); chk("R6 unmapped", d, 8'h00);
    wr(8'h0F, 8'hFE);
    rd(8'h0F, d); chk("R6 slot idx keeps bit0 only", d, 8'h00);
  endtask

  task automatic t_ids();
    logic [7:0] d;
    rd(8'h5A, d); chk("R7 id 5A", d, 8'h07);
    rd(8'h5C, d); chk("R7 id 5C", d, 8'h30);
    rd(8'h5D, d); chk("R7 id 5D", d, 8'h19);
    rd(8'h5E, d); chk("R7 id 5E", d, 8'h34);
  endtask

  task automatic t_wdt_count();
    logic [7:0] d;
    wr(8'h13, 8'h85);
    repeat (2) @(negedge clk);
    rd(8'h13, d); chk("R8 before first tick", d, 8'h85);
    rd(8'h13, d); chk("R8 after first tick", d, 8'h84);
    wr(8'h13, 8'h00);
    rd(8'h13, d); chk("R8 disarmed", d, 8'h00);
  endtask

  task automatic wait_fire(output int cyc);
    cyc = 0;
    while (cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (fire) break;
    end
  endtask

  task automatic t_wdt_fire();
    logic [7:0] d;
    int cyc;
    unlock();
    wr(8'h04, 8'hA5);
    wr(8'h13, 8'h83);
    wait_fire(cyc);
    chk("R9 expiry cycle", cyc, 4 * DIV);
    rd(8'h04, d);
    chk("R9 pulse one cycle", fire, 0);
    chk("R9 regs cleared", d, 8'h00);
    chk("R9 relocked", unlocked, 0);
    rd(8'h13, d); chk("R9 enable cleared", d, 8'h00);
  endtask

  task automatic t_wdt_reload();
    int cyc;
    wr(8'h13, 8'h85);
    repeat (10) @(negedge clk);
    chk("R10 no early pulse", fire, 0);
    wr(8'h13, 8'h82);
    wait_fire(cyc);
    chk("R10 reload restarts", cyc, 3 * DIV);
  endtask

  task automatic t_slot();
    logic [7:0] d;
    unlock();
    wr(8'h08, 8'h3C);
    wr(8'h0F, 8'h00);
    @(negedge clk); slot_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 disabled pin no effect", ovs0, 8'h3C);
    chk("R11 disabled pin keeps unlock", unlocked, 1);
    slot_n = 1'b1;
    repeat (3) @(negedge clk);
    wr(8'h0F, 8'h01);
    @(negedge clk); slot_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 pin clears regs", ovs0, 8'h00);
    chk("R11 pin relocks", unlocked, 0);
    slot_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(8'h0F, d); chk("R11 enable bit kept", d, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unlock();
    t_relock();
    t_bad_seq();
    t_protect();
    t_ids();
    t_wdt_count();
    t_wdt_fire();
    t_wdt_reload();
    t_slot();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule